// File: doc/BRIEF.md
# Overload Retry Sequencer for an Antenna Supply Output

This block decides when the power stage of an antenna supply output may conduct and when an overload must be reported. It watches a digital overcurrent comparator and a pair of thermal inputs. It drives a power-stage enable, a current-limit request, an overload flag and an over-temperature flag. All time constants are parameters counted in clock cycles.

When the output is enabled, the block first runs a soft-start interval. During that interval the comparator is ignored and the overload flag is held low. After soft-start it runs in one of two modes, chosen by a mode input.

- In the default (dynamic) mode, an overload switches the stage off for a long rest period and raises the flag. The stage then retries for a short window with the current limit applied. The rest/retry pair repeats until one whole retry window passes with no overload. Only then does normal running resume and the flag drop.
- In static mode the stage is never switched off. The current clamp stays applied and the flag simply tracks the comparator.

Thermal shutdown is independent of the sequencer. It gates the enable output until the cool-down input reports the lower threshold.

Top module: `overload_seq`

## Requirements
- R1: While reset is asserted, and straight after it, `pwr_en_o`, `olf_o`, `ilim_o` and `otf_o` are all 0.
- R2: After `en_i` is sampled high while idle, `pwr_en_o` is 1 for exactly SS_CYC cycles of soft-start. During soft-start `ovc_i` is ignored and `olf_o` stays 0. Normal running follows with `olf_o` still 0.
- R3: In normal running with `static_i`=0, a sampled `ovc_i`=1 drives `pwr_en_o` to 0 and `olf_o` to 1 on the next cycle. The stage then stays off for exactly T_OFF cycles.
- R4: When the off period ends, `pwr_en_o` and `ilim_o` are 1 for a retry window of exactly T_ON cycles, and `olf_o` stays 1.
- R5: If `ovc_i` is sampled high in any cycle of a retry window, another off period of T_OFF cycles follows, with `olf_o` held at 1.
- R6: A retry window with no overload sample returns to normal running, and `olf_o` and `ilim_o` fall to 0.
- R7: With `static_i`=1 in normal running, `pwr_en_o` stays 1 and `ilim_o` is 1. `olf_o` equals the value of `ovc_i` sampled one cycle earlier.
- R8: Setting `static_i` to 1 during an off period or a retry window ends the cycle at once. The block returns to normal running with the stage on.
- R9: Clearing `static_i` to 0 while `ovc_i` is high starts the dynamic cycle at its off period.
- R10: `en_i` sampled low returns the block to idle, with `pwr_en_o`=0 and `olf_o`=0 on the next cycle.
- R11: `hot_i` sampled high sets `otf_o` and forces `pwr_en_o` to 0 on the next cycle. `otf_o` clears only when `cool_i` is sampled high with `hot_i` low. The sequencer timing continues unaffected while the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Output enable from the control register |
| static_i | input | 1 | 1 selects static clamp mode, 0 dynamic retry mode |
| ovc_i | input | 1 | Overcurrent comparator, synchronised |
| hot_i | input | 1 | Junction above upper thermal threshold |
| cool_i | input | 1 | Junction below lower thermal threshold |
| pwr_en_o | output | 1 | Power-stage enable |
| ilim_o | output | 1 | Current-limit clamp request |
| olf_o | output | 1 | Overload flag |
| otf_o | output | 1 | Over-temperature flag |

## Verification
The hardest situation to reach is an overload that appears only in the middle of a retry window and is gone by the window's last cycle. That case must still force another off period. The stimulus counts cycles exactly from the comparator edge so that it can pulse the comparator in a chosen window cycle. It then holds the comparator low through the window's end. The mode input is also flipped in the middle of an off period and while an overload is pending, to reach the abort and restart paths.

// File: rtl/olseq_pkg.sv
package olseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SOFT  = 3'd1,
      ST_RUN   = 3'd2,
      ST_REST  = 3'd3,
      ST_RETRY = 3'd4
   } seq_state_t;
endpackage

// File: rtl/olseq_timer.sv
module olseq_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   output logic          expired
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (ld)             cnt <= ld_val;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // counter parks at zero rather than wrapping (supports R3, R4)
   p_cnt_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/olseq_thermal.sv
module olseq_thermal (
   input  logic clk,
   input  logic rst_n,
   input  logic hot_i,
   input  logic cool_i,
   output logic otf_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                otf_o <= 1'b0;
      else if (hot_i)            otf_o <= 1'b1;
      else if (cool_i)           otf_o <= 1'b0;
   end

   p_otf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (otf_o && !cool_i) |=> otf_o);
endmodule

// File: rtl/overload_seq.sv
module overload_seq
   import olseq_pkg::*;
#(
   parameter int SS_CYC = 1024,
   parameter int T_OFF  = 900000,
   parameter int T_ON   = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic static_i,
   input  logic ovc_i,
   input  logic hot_i,
   input  logic cool_i,
   output logic pwr_en_o,
   output logic ilim_o,
   output logic olf_o,
   output logic otf_o
);
   localparam int MAX_A = (SS_CYC > T_OFF) ? SS_CYC : T_OFF;
   localparam int MAX_C = (MAX_A > T_ON) ? MAX_A : T_ON;
   localparam int CW    = $clog2(MAX_C) + 1;
   localparam logic [CW-1:0] SS_LD  = CW'(SS_CYC - 1);
   localparam logic [CW-1:0] OFF_LD = CW'(T_OFF - 1);
   localparam logic [CW-1:0] ON_LD  = CW'(T_ON - 1);

   generate
      if (SS_CYC < 1) begin : g_bad_ss
         $error("SS_CYC must be at least 1");
      end
      if (T_OFF < 1) begin : g_bad_off
         $error("T_OFF must be at least 1");
      end
      if (T_ON < 1) begin : g_bad_on
         $error("T_ON must be at least 1");
      end
   endgenerate

   seq_state_t    st, st_nx;
   logic          olf_nx, seen, seen_nx;
   logic          ld;
   logic [CW-1:0] ld_val;
   logic          expired;

   olseq_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .expired(expired)
   );

   olseq_thermal u_therm (
      .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .cool_i(cool_i), .otf_o(otf_o)
   );

   always_comb begin
      st_nx   = st;
      olf_nx  = olf_o;
      seen_nx = seen;
      ld      = 1'b0;
      ld_val  = '0;
      if (!en_i) begin
         st_nx  = ST_IDLE;
         olf_nx = 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               st_nx  = ST_SOFT;
               ld     = 1'b1;
               ld_val = SS_LD;
               olf_nx = 1'b0;
            end
            ST_SOFT: begin
               olf_nx = 1'b0;
               if (expired) st_nx = ST_RUN;
            end
            ST_RUN: begin
               if (static_i) begin
                  olf_nx = ovc_i;
               end else if (ovc_i) begin
                  st_nx  = ST_REST;
                  ld     = 1'b1;
                  ld_val = OFF_LD;
                  olf_nx = 1'b1;
               end else begin
                  olf_nx = 1'b0;
               end
            end
            ST_REST: begin
               if (static_i) begin
                  st_nx  = ST_RUN;
                  olf_nx = ovc_i;
               end else if (expired) begin
                  st_nx   = ST_RETRY;
                  ld      = 1'b1;
                  ld_val  = ON_LD;
                  seen_nx = 1'b0;
               end
            end
            ST_RETRY: begin
               if (static_i) begin
                  st_nx  = ST_RUN;
                  olf_nx = ovc_i;
               end else if (expired) begin
                  if (seen || ovc_i) begin
                     st_nx  = ST_REST;
                     ld     = 1'b1;
                     ld_val = OFF_LD;
                  end else begin
                     st_nx  = ST_RUN;
                     olf_nx = 1'b0;
                  end
               end else if (ovc_i) begin
                  seen_nx = 1'b1;
               end
            end
            default: st_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         olf_o <= 1'b0;
         seen  <= 1'b0;
      end else begin
         st    <= st_nx;
         olf_o <= olf_nx;
         seen  <= seen_nx;
      end
   end

   assign pwr_en_o = !otf_o && (st == ST_SOFT || st == ST_RUN || st == ST_RETRY);
   assign ilim_o   = (st == ST_RETRY) || (st == ST_RUN && static_i);

   p_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && st == ST_RUN && !static_i && ovc_i) |=> (olf_o && !pwr_en_o));
   p_soft_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SOFT) |-> !olf_o);
   p_static_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && static_i && st == ST_RUN) |=> (olf_o == $past(ovc_i)));
   p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!olf_o && !pwr_en_o));
   p_hot_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hot_i |=> (otf_o && !pwr_en_o));
   p_rest_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_REST) |-> olf_o);
endmodule

// File: tb/overload_seq_tb.sv
module overload_seq_tb;
   localparam int SS = 4;
   localparam int TO = 5;
   localparam int TN = 3;

   typedef struct {
      logic  pwr, olf, ilim, otf;
      string tag;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 0, st_m = 0, ovc = 0, hot = 0, cool = 0;
   logic pwr_en, ilim, olf, otf;
   int   checks = 0, fails = 0;
   bit   done = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   overload_seq #(.SS_CYC(SS), .T_OFF(TO), .T_ON(TN)) u_dut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .static_i(st_m), .ovc_i(ovc),
      .hot_i(hot), .cool_i(cool), .pwr_en_o(pwr_en), .ilim_o(ilim),
      .olf_o(olf), .otf_o(otf)
   );

   task automatic compare(input exp_t e);
      checks++;
      if ({pwr_en, olf, ilim, otf} !== {e.pwr, e.olf, e.ilim, e.otf}) begin
         fails++;
         $display("FAIL %s: pwr/olf/ilim/otf got %b%b%b%b exp %b%b%b%b", e.tag,
                  pwr_en, olf, ilim, otf, e.pwr, e.olf, e.ilim, e.otf);
      end
   endtask

   // driver: apply inputs before an edge, push what the outputs must be after it
   task automatic step(input logic e, d, o, h, c,
                       input logic xp, xo, xi, xt, input string tg);
      exp_t it;
      @(negedge clk);
      en = e; st_m = d; ovc = o; hot = h; cool = c;
      @(posedge clk);
      #1;
      it.pwr = xp; it.olf = xo; it.ilim = xi; it.otf = xt; it.tag = tg;
      q.push_back(it);
   endtask

   // monitor
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) compare(q.pop_front());
   end

   initial begin
      exp_t r;
      #1;
      r.pwr = 0; r.olf = 0; r.ilim = 0; r.otf = 0; r.tag = "R1 in reset";
      compare(r);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      r.tag = "R1 after reset";
      compare(r);
      // R2: soft-start ignores the comparator
      for (int i = 0; i < SS; i++) step(1,0,1,0,0, 1,0,0,0, "R2 soft-start");
      step(1,0,0,0,0, 1,0,0,0, "R2 run after soft-start");
      // R3: trip and rest
      step(1,0,1,0,0, 0,1,0,0, "R3 trip");
      for (int i = 1; i < TO; i++) step(1,0,0,0,0, 0,1,0,0, "R3 rest length");
      // R4: retry window, with mid-window overload (R5)
      step(1,0,0,0,0, 1,1,1,0, "R4 retry start");
      step(1,0,1,0,0, 1,1,1,0, "R4 retry mid overload");
      step(1,0,0,0,0, 1,1,1,0, "R4 retry last");
      for (int i = 0; i < TO; i++) step(1,0,0,0,0, 0,1,0,0, "R5 second rest");
      for (int i = 0; i < TN; i++) step(1,0,0,0,0, 1,1,1,0, "R4 clean retry");
      step(1,0,0,0,0, 1,0,0,0, "R6 resume");
      step(1,0,0,0,0, 1,0,0,0, "R6 steady");
      // R7: static mode
      step(1,1,1,0,0, 1,1,1,0, "R7 static flag up");
      step(1,1,0,0,0, 1,0,1,0, "R7 static flag down");
      step(1,1,1,0,0, 1,1,1,0, "R7 static flag up again");
      // R9: back to dynamic with overload pending
      step(1,0,1,0,0, 0,1,0,0, "R9 dynamic restart");
      step(1,0,0,0,0, 0,1,0,0, "R9 resting");
      // R8: static aborts rest
      step(1,1,0,0,0, 1,0,1,0, "R8 abort to run");
      step(1,0,0,0,0, 1,0,0,0, "R8 dynamic run");
      // R10: disable during rest
      step(1,0,1,0,0, 0,1,0,0, "R10 trip");
      step(0,0,0,0,0, 0,0,0,0, "R10 disable");
      step(0,0,1,0,0, 0,0,0,0, "R10 idle holds");
      // R11: thermal during soft-start
      step(1,0,0,0,0, 1,0,0,0, "R2 restart soft");
      step(1,0,0,1,0, 0,0,0,1, "R11 hot");
      step(1,0,0,0,0, 0,0,0,1, "R11 flag held");
      step(1,0,0,0,1, 1,0,0,0, "R11 cooled");
      step(1,0,0,0,0, 1,0,0,0, "R11 run after soft");
      repeat (3) @(posedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: got timeout exp completion");
         end
      join_any
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule